// File: doc/BRIEF.md
# Show-Cycle Bus Driver

This block makes accesses on an internal processor bus visible on the external bus, so that a debugger or logic analyser can follow them. An internal requester presents a transaction through a valid/ready handshake. The transaction carries an address, a read/write flag, a size, a burst flag, an instruction/data flag, an alternate-master flag and the data. The block captures it and replays it on the external pins with a fixed two-phase timing.

The first cycle is the address phase. In it the block drives the address, the space attributes, the size code and the active-low burst pin, and it asserts a start strobe for one clock. The second cycle is the data phase. In it the block itself drives the data for reads as well as for writes. Instruction accesses skip the data phase. A burst shows only its first beat.

No acknowledge is awaited. A one-clock done pulse marks the last phase of the cycle, and the block returns to idle on the next clock. The privilege attribute is taken live from the core's current privilege input during the address phase. It is not taken from the moment the request was accepted.

Top module: `showcycle_driver`

## Requirements
- R1: After reset, and in every cycle with no show cycle in progress, the block holds the idle values. Both output enables are 0 and `bus_start` is 0. `bus_blk_n` is 1. `bus_addr`, `bus_data`, `bus_space` and `bus_szcode` are 0. `bus_wr`, `bus_fetch`, `bus_user` and `done` are 0. `req_ready` is 1.
- R2: `req_ready` is 1 only while idle. A request is accepted at a rising edge where `req_valid` and `req_ready` are both 1. Its address phase occupies the cycle that follows that edge.
- R3: The address phase lasts exactly one cycle. In it `bus_addr_en` and `bus_start` are 1, `bus_addr` carries the captured address and `bus_wr` carries the captured write flag.
- R4: For a data access, the cycle right after the address phase is the data phase, and it lasts exactly one cycle. In it `bus_data_en` is 1 and `bus_data` carries the captured data, for reads and writes alike. `bus_addr_en` and `bus_start` are 0 in that cycle.
- R5: An instruction access (`req_instr`=1) has no data phase. The block returns to idle in the cycle after its address phase.
- R6: `done` is a single-cycle pulse in the last phase of each show cycle. For data accesses that is the data phase; for instruction accesses it is the address phase. No acknowledge input exists.
- R7: With `req_burst`=0, `bus_blk_n` is 1 during the address phase. `bus_szcode` is then chosen by `req_size`: size 0 (byte) gives 2'b01, size 1 (half-word) gives 2'b10, and size 2 (word) gives 2'b00.
- R8: With `req_burst`=1, the address phase drives `bus_blk_n`=0 and `bus_szcode`=2'b00, which means a 16-byte burst. Only one data phase follows.
- R9: During the address phase `bus_space` is {alt, super, instr, ~instr}. In the same phase `bus_fetch` equals instr and `bus_user` equals ~super.
- R10: The super value used by R9 is `core_super` as sampled in the address-phase cycle, even if it differed when the request was accepted.
- R11: A request held valid while a show cycle is in progress is not accepted and does not disturb the pins of that cycle. It is accepted on the idle cycle that follows `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Internal request valid |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | AW | Internal access address |
| req_data | input | DW | Internal access data (first beat) |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 half-word, 2 word |
| req_burst | input | 1 | Access is a burst |
| req_instr | input | 1 | Instruction access |
| req_alt | input | 1 | Alternate master originated the access |
| core_super | input | 1 | Current privilege of the master (1 = supervisor) |
| bus_addr | output | AW | External address |
| bus_addr_en | output | 1 | Address/attribute pins driven |
| bus_wr | output | 1 | External write flag |
| bus_space | output | 4 | Address-space attribute code |
| bus_fetch | output | 1 | Instruction-fetch attribute |
| bus_user | output | 1 | User-mode attribute |
| bus_szcode | output | 2 | Transfer-size code |
| bus_blk_n | output | 1 | Burst indicator, active low |
| bus_start | output | 1 | One-clock transaction start strobe |
| bus_data | output | DW | External data |
| bus_data_en | output | 1 | Data pins driven |
| done | output | 1 | Show cycle complete |

## Verification
A phase register stuck or advanced wrongly appears in the very next cycle: the start strobe lasts two clocks, a data phase appears after an instruction access, or `req_ready` comes back early. A wrongly captured field appears during the address phase or the data phase of the same transaction as a wrong address, size code, attribute or data word. A privilege bit latched instead of sampled live shows as a wrong `bus_user`/`bus_space[2]` in the address phase. That only happens when the bench flips `core_super` between acceptance and the address phase, which it does on purpose.

// File: rtl/showcycle_pkg.sv
package showcycle_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_DATA = 2'd2
    } phase_e;

    localparam logic [1:0] RQ_BYTE = 2'd0;
    localparam logic [1:0] RQ_HALF = 2'd1;
    localparam logic [1:0] RQ_WORD = 2'd2;

    typedef struct packed {
        logic       wr;
        logic [1:0] size;
        logic       burst;
        logic       instr;
        logic       alt;
    } rq_attr_t;

    // Size code driven on the pins; a burst always reports 00.
    function automatic logic [1:0] size_code(input logic [1:0] sz, input logic burst);
        if (burst) return 2'b00;
        case (sz)
            RQ_BYTE: return 2'b01;
            RQ_HALF: return 2'b10;
            default: return 2'b00;
        endcase
    endfunction

    // Space attribute: {alternate, supervisor, instruction, data}.
    function automatic logic [3:0] space_code(input logic alt, input logic sup, input logic instr);
        return {alt, sup, instr, ~instr};
    endfunction

endpackage

// File: rtl/sc_capture.sv
module sc_capture
    import showcycle_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          accept,
    input  logic [AW-1:0] in_addr,
    input  logic [DW-1:0] in_data,
    input  rq_attr_t      in_attr,
    output logic [AW-1:0] addr_q,
    output logic [DW-1:0] data_q,
    output rq_attr_t      attr_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            data_q <= '0;
            attr_q <= '0;
        end else if (accept) begin
            addr_q <= in_addr;
            data_q <= in_data;
            attr_q <= in_attr;
        end
    end

endmodule

// File: rtl/sc_sequencer.sv
module sc_sequencer
    import showcycle_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   req_valid,
    input  logic   instr_q,
    output phase_e phase,
    output logic   ready,
    output logic   accept,
    output logic   done
);

    assign ready  = (phase == PH_IDLE);
    assign accept = req_valid && ready;
    assign done   = (phase == PH_DATA) || ((phase == PH_ADDR) && instr_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
        end else begin
            case (phase)
                PH_IDLE: if (accept) phase <= PH_ADDR;
                PH_ADDR: phase <= instr_q ? PH_IDLE : PH_DATA;
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // R3
    addr_single_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_ADDR) |=> (phase != PH_ADDR));

    // R4
    data_after_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_DATA) |-> ($past(phase) == PH_ADDR));

    // R5
    instr_no_data_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_ADDR && instr_q) |=> (phase == PH_IDLE));

    // R6
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R11
    busy_no_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_IDLE) |-> !accept);

endmodule

// File: rtl/sc_pin_encode.sv
module sc_pin_encode
    import showcycle_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  phase_e        phase,
    input  logic [AW-1:0] addr_q,
    input  logic [DW-1:0] data_q,
    input  rq_attr_t      attr_q,
    input  logic          core_super,
    output logic [AW-1:0] bus_addr,
    output logic          bus_addr_en,
    output logic          bus_wr,
    output logic [3:0]    bus_space,
    output logic          bus_fetch,
    output logic          bus_user,
    output logic [1:0]    bus_szcode,
    output logic          bus_blk_n,
    output logic          bus_start,
    output logic [DW-1:0] bus_data,
    output logic          bus_data_en
);

    logic in_addr, in_data;

    assign in_addr = (phase == PH_ADDR);
    assign in_data = (phase == PH_DATA);

    always_comb begin
        bus_addr_en = in_addr;
        bus_start   = in_addr;
        bus_addr    = in_addr ? addr_q : '0;
        bus_wr      = in_addr && attr_q.wr;
        bus_space   = in_addr ? space_code(attr_q.alt, core_super, attr_q.instr) : 4'd0;
        bus_fetch   = in_addr && attr_q.instr;
        bus_user    = in_addr && !core_super;
        bus_szcode  = in_addr ? size_code(attr_q.size, attr_q.burst) : 2'b00;
        bus_blk_n   = !(in_addr && attr_q.burst);
        bus_data_en = in_data;
        bus_data    = in_data ? data_q : '0;
    end

    // R8
    burst_size_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_blk_n |-> (bus_szcode == 2'b00 && bus_addr_en));

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!bus_addr_en && !bus_data_en) |-> (bus_addr == '0 && bus_data == '0 && !bus_start && bus_blk_n));

    // R4
    phase_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(bus_addr_en && bus_data_en));

endmodule

// File: rtl/showcycle_driver.sv
module showcycle_driver
    import showcycle_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_data,
    input  logic          req_wr,
    input  logic [1:0]    req_size,
    input  logic          req_burst,
    input  logic          req_instr,
    input  logic          req_alt,
    input  logic          core_super,
    output logic [AW-1:0] bus_addr,
    output logic          bus_addr_en,
    output logic          bus_wr,
    output logic [3:0]    bus_space,
    output logic          bus_fetch,
    output logic          bus_user,
    output logic [1:0]    bus_szcode,
    output logic          bus_blk_n,
    output logic          bus_start,
    output logic [DW-1:0] bus_data,
    output logic          bus_data_en,
    output logic          done
);

    phase_e        phase;
    logic          accept;
    rq_attr_t      attr_in, attr_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] data_q;

    always_comb begin
        attr_in.wr    = req_wr;
        attr_in.size  = req_size;
        attr_in.burst = req_burst;
        attr_in.instr = req_instr;
        attr_in.alt   = req_alt;
    end

    sc_sequencer u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .instr_q   (attr_q.instr),
        .phase     (phase),
        .ready     (req_ready),
        .accept    (accept),
        .done      (done)
    );

    sc_capture #(.AW(AW), .DW(DW)) u_cap (
        .clk     (clk),
        .rst     (rst),
        .accept  (accept),
        .in_addr (req_addr),
        .in_data (req_data),
        .in_attr (attr_in),
        .addr_q  (addr_q),
        .data_q  (data_q),
        .attr_q  (attr_q)
    );

    sc_pin_encode #(.AW(AW), .DW(DW)) u_pins (
        .clk         (clk),
        .rst         (rst),
        .phase       (phase),
        .addr_q      (addr_q),
        .data_q      (data_q),
        .attr_q      (attr_q),
        .core_super  (core_super),
        .bus_addr    (bus_addr),
        .bus_addr_en (bus_addr_en),
        .bus_wr      (bus_wr),
        .bus_space   (bus_space),
        .bus_fetch   (bus_fetch),
        .bus_user    (bus_user),
        .bus_szcode  (bus_szcode),
        .bus_blk_n   (bus_blk_n),
        .bus_start   (bus_start),
        .bus_data    (bus_data),
        .bus_data_en (bus_data_en)
    );

    // R2
    start_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
        accept |=> (bus_start && !req_ready));

endmodule

// File: tb/test_showcycle_driver.sv
module test_showcycle_driver;

    localparam int AW = 32;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_data = '0;
    logic          req_wr = 1'b0;
    logic [1:0]    req_size = 2'd0;
    logic          req_burst = 1'b0;
    logic          req_instr = 1'b0;
    logic          req_alt = 1'b0;
    logic          core_super = 1'b0;
    logic [AW-1:0] bus_addr;
    logic          bus_addr_en, bus_wr, bus_fetch, bus_user, bus_blk_n, bus_start;
    logic [3:0]    bus_space;
    logic [1:0]    bus_szcode;
    logic [DW-1:0] bus_data;
    logic          bus_data_en, done;

    int vectors = 0;
    int fails   = 0;
    int cycles  = 0;

    always #4 clk = ~clk;

    showcycle_driver #(.AW(AW), .DW(DW)) i_showcycle_driver (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_data(req_data), .req_wr(req_wr),
        .req_size(req_size), .req_burst(req_burst), .req_instr(req_instr),
        .req_alt(req_alt), .core_super(core_super),
        .bus_addr(bus_addr), .bus_addr_en(bus_addr_en), .bus_wr(bus_wr),
        .bus_space(bus_space), .bus_fetch(bus_fetch), .bus_user(bus_user),
        .bus_szcode(bus_szcode), .bus_blk_n(bus_blk_n), .bus_start(bus_start),
        .bus_data(bus_data), .bus_data_en(bus_data_en), .done(done)
    );

    function automatic logic [1:0] exp_sz(input logic [1:0] sz, input logic burst);
        if (burst) return 2'b00;
        if (sz == 2'd0) return 2'b01;
        if (sz == 2'd1) return 2'b10;
        return 2'b00;
    endfunction

    function automatic logic [3:0] exp_space(input logic alt, input logic sup, input logic instr);
        return {alt, sup, instr, !instr};
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_idle(input string tag);
        chk({tag, " R1 addr_en"}, bus_addr_en, 0);
        chk({tag, " R1 data_en"}, bus_data_en, 0);
        chk({tag, " R1 start"},   bus_start, 0);
        chk({tag, " R1 blk_n"},   bus_blk_n, 1);
        chk({tag, " R1 addr"},    bus_addr, 0);
        chk({tag, " R1 data"},    bus_data, 0);
        chk({tag, " R1 space"},   bus_space, 0);
        chk({tag, " R1 szcode"},  bus_szcode, 0);
        chk({tag, " R1 fetch/user/wr"}, {bus_fetch, bus_user, bus_wr}, 0);
        chk({tag, " R6 done idle"}, done, 0);
        chk({tag, " R2 ready idle"}, req_ready, 1);
    endtask

    task automatic chk_addr_phase(input logic [AW-1:0] a, input logic wr, input logic [1:0] sz,
                                  input logic burst, input logic instr, input logic alt, input logic sup);
        chk("R3 addr_en", bus_addr_en, 1);
        chk("R3 start", bus_start, 1);
        chk("R3 addr", bus_addr, a);
        chk("R3 wr", bus_wr, wr);
        chk("R2 ready busy", req_ready, 0);
        chk("R7 szcode", bus_szcode, exp_sz(sz, burst));
        chk("R8 blk_n", bus_blk_n, !burst);
        chk("R9 space", bus_space, exp_space(alt, sup, instr));
        chk("R9 fetch", bus_fetch, instr);
        chk("R10 user live", bus_user, !sup);
        chk("R4 no data in addr", bus_data_en, 0);
        chk("R5 R6 done in addr", done, instr);
    endtask

    task automatic chk_data_phase(input logic [DW-1:0] d);
        chk("R4 data_en", bus_data_en, 1);
        chk("R4 data", bus_data, d);
        chk("R3 addr gone", {bus_addr_en, bus_start}, 0);
        chk("R6 done data", done, 1);
        chk("R11 ready busy", req_ready, 0);
    endtask

    task automatic run(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic wr,
                       input logic [1:0] sz, input logic burst, input logic instr,
                       input logic alt, input logic sup_acc, input logic sup_live);
        @(negedge clk);
        req_valid = 1; req_addr = a; req_data = d; req_wr = wr; req_size = sz;
        req_burst = burst; req_instr = instr; req_alt = alt; core_super = sup_acc;
        #1;
        while (!req_ready) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        req_valid = 0; req_addr = ~a; req_data = ~d; core_super = sup_live;
        #1;
        chk_addr_phase(a, wr, sz, burst, instr, alt, sup_live);
        if (!instr) begin
            @(negedge clk);
            #1;
            chk_data_phase(d);
        end
        @(negedge clk);
        #1;
        chk_idle("end R5 R8");
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            fails++;
            $display("FAIL watchdog R6 actual=timeout expected=completion");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        #1;
        chk_idle("reset");
        rst = 0;
        @(negedge clk);
        #1;
        chk_idle("after reset");

        // R7 each size, read and write
        run(32'h1000_0001, 32'hAABB_CCDD, 1, 2'd0, 0, 0, 0, 1, 1);
        run(32'h1000_0002, 32'h1122_3344, 0, 2'd1, 0, 0, 1, 0, 0);
        run(32'h1000_0004, 32'h5566_7788, 1, 2'd2, 0, 0, 0, 1, 1);
        // R8 burst read, one beat
        run(32'h2000_0010, 32'hDEAD_BEEF, 0, 2'd2, 1, 0, 1, 1, 1);
        // R5 instruction show cycle
        run(32'h3000_0100, 32'h0, 0, 2'd2, 0, 1, 0, 1, 1);
        // R10 privilege changes between acceptance and address phase
        run(32'h4000_0000, 32'h0F0F_0F0F, 1, 2'd0, 0, 0, 0, 1, 0);
        run(32'h4000_0020, 32'hF0F0_F0F0, 0, 2'd1, 0, 1, 1, 0, 1);

        // R11 stall: second request held during the first cycle
        @(negedge clk);
        req_valid = 1; req_addr = 32'h5000_0000; req_data = 32'h1234_5678; req_wr = 1;
        req_size = 2'd2; req_burst = 0; req_instr = 0; req_alt = 0; core_super = 1;
        @(negedge clk);
        req_addr = 32'h6000_0008; req_data = 32'h8765_4321; req_wr = 0; req_size = 2'd1;
        #1;
        chk("R11 first addr held", bus_addr, 32'h5000_0000);
        chk("R11 not ready addr", req_ready, 0);
        @(negedge clk);
        #1;
        chk("R11 first data held", bus_data, 32'h1234_5678);
        chk("R11 not ready data", req_ready, 0);
        @(negedge clk);
        #1;
        chk("R11 idle gap ready", req_ready, 1);
        chk("R11 idle gap no start", bus_start, 0);
        @(negedge clk);
        req_valid = 0;
        #1;
        chk_addr_phase(32'h6000_0008, 0, 2'd1, 0, 0, 0, 1);
        @(negedge clk);
        #1;
        chk_data_phase(32'h8765_4321);
        @(negedge clk);
        #1;
        chk_idle("R11 end");

        // Random mix
        for (int i = 0; i < 60; i++) begin
            logic [AW-1:0] a;
            logic [DW-1:0] d;
            logic [1:0] sz;
            a  = $urandom;
            d  = $urandom;
            sz = 2'($urandom % 3);
            run(a, d, 1'($urandom), sz, 1'($urandom % 4 == 0), 1'($urandom % 3 == 0),
                1'($urandom), 1'($urandom), 1'($urandom));
        end

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule